// File: doc/BRIEF.md
# Signal-Failure Defect Monitor

This block decides whether a receive line is in a Signal Failure defect state from the parity errors it reports. Each time the upstream overhead checker finds B2 (BIP-24) mismatches, it strobes the count into the monitor. The monitor adds these counts over a monitoring window. The window length is set in milliseconds and is paced by an external 1 ms tick. When the window closes, the monitor compares the window total with two programmable limits. A total strictly above the set limit raises the defect. Once the defect is raised, a later window whose total is at or below the clear limit removes it. Using two limits gives the flag hysteresis.

Configuration arrives as byte writes on a small select/data port. Any such write restarts the running window, so a half-finished window never mixes old and new settings. Every change of the defect flag is marked by a single-cycle pulse that an interrupt controller can latch.

Top module: `sf_defect_monitor`

## Requirements
- R1: The window length is a 24-bit count of ms ticks, written one byte at a time with `cfg_sel` 0 (bits 7:0), 1 (bits 15:8) and 2 (bits 23:16). It resets to 0. The window closes on the tick that completes that many ticks.
- R2: The set limit is written at `cfg_sel` 3 (low byte) and 4 (high byte). The clear limit is written at `cfg_sel` 5 (low byte) and 6 (high byte). Both limits reset to 0xFFFF.
- R3: Every `err_cnt` strobed with `err_vld` during a window counts toward its total, including a strobe in the same cycle as the closing tick. The total saturates at 0xFFFF and does not wrap.
- R4: While the flag is clear, a window total strictly greater than the set limit raises `sf_active`. A total equal to the set limit does not.
- R5: While the flag is raised, a window total less than or equal to the clear limit lowers `sf_active`. A larger total keeps it raised.
- R6: The flag changes only when a window closes. After each close the total starts again from zero.
- R7: A window length of 0 disables the monitor. `sf_active` is then forced low on the next clock and stays low whatever errors or ticks arrive.
- R8: Any configuration write restarts the current window from zero ticks and zero errors. The cycle of the write also discards an error strobe and a window close.
- R9: `sf_change` is high for exactly one cycle, in the same cycle that `sf_active` shows its new value, on every change of the flag. This includes a change forced by R7. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| err_vld | input | 1 | Error count strobe |
| err_cnt | input | ERR_W (8) | Parity errors in this strobe |
| cfg_wr | input | 1 | Configuration byte write |
| cfg_sel | input | SEL_W (3) | Byte select, map in R1 and R2 |
| cfg_wdata | input | 8 | Byte written |
| sf_active | output | 1 | Signal Failure defect state |
| sf_change | output | 1 | One-cycle pulse on each flag change |

## Verification
The bench uses a total exactly equal to the set limit; a design using greater-or-equal would raise the flag there. It drives enough errors to pass 0xFFFF against a set limit of 0xFFFE; a wrapping accumulator would end with a small total and never raise the flag, while the reset limit of 0xFFFF must never fire even at saturation. Errors are placed on the closing tick, a write is issued mid-window, and a 256-tick window is run. These catch a design that loses the last strobe, keeps pre-write errors or decodes only the low window byte. A forced clear through a zero window must also pulse `sf_change`.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  localparam int TOT_W = 16;

  // Saturating addition of a window total and a new error count.
  function automatic logic [TOT_W-1:0] sat_add(input logic [TOT_W-1:0] acc,
                                                input logic [TOT_W-1:0] inc);
    logic [TOT_W:0] wide;
    wide = {1'b0, acc} + {1'b0, inc};
    return wide[TOT_W] ? {TOT_W{1'b1}} : wide[TOT_W-1:0];
  endfunction

  // Hysteresis decision taken when a window closes.
  function automatic logic next_flag(input logic             cur,
                                     input logic [TOT_W-1:0] total,
                                     input logic [TOT_W-1:0] set_lim,
                                     input logic [TOT_W-1:0] clr_lim);
    if (!cur) return total > set_lim;
    return !(total <= clr_lim);
  endfunction

endpackage

// File: rtl/sfm_cfg_regs.sv
module sfm_cfg_regs #(
  parameter int WIN_W = 24,
  parameter int THR_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic [WIN_W-1:0] win_len,
  output logic [THR_W-1:0] set_lim,
  output logic [THR_W-1:0] clr_lim,
  output logic             restart
);
  localparam int WIN_B   = (WIN_W + 7) / 8;
  localparam int THR_B   = (THR_W + 7) / 8;
  localparam int SET_BASE = WIN_B;
  localparam int CLR_BASE = WIN_B + THR_B;

  logic [WIN_B*8-1:0] win_q;
  logic [THR_B*8-1:0] set_q;
  logic [THR_B*8-1:0] clr_q;

  for (genvar b = 0; b < WIN_B; b++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) win_q[b*8 +: 8] <= 8'h00;
      else if (cfg_wr && cfg_sel == SEL_W'(b)) win_q[b*8 +: 8] <= cfg_wdata;
    end
  end

  for (genvar b = 0; b < THR_B; b++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        set_q[b*8 +: 8] <= 8'hFF;
        clr_q[b*8 +: 8] <= 8'hFF;
      end else if (cfg_wr) begin
        if (cfg_sel == SEL_W'(SET_BASE + b)) set_q[b*8 +: 8] <= cfg_wdata;
        if (cfg_sel == SEL_W'(CLR_BASE + b)) clr_q[b*8 +: 8] <= cfg_wdata;
      end
    end
  end

  assign win_len = win_q[WIN_W-1:0];
  assign set_lim = set_q[THR_W-1:0];
  assign clr_lim = clr_q[THR_W-1:0];
  assign restart = cfg_wr;

  // R2: limits come out of reset at all ones
  a_r2_reset_limits: assert property (@(posedge clk)
    !rst_n |=> (set_lim == {THR_W{1'b1}} && clr_lim == {THR_W{1'b1}}));
endmodule

// File: rtl/sfm_window_timer.sv
module sfm_window_timer #(
  parameter int WIN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enabled,
  input  logic             restart,
  input  logic             ms_tick,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end
);
  logic [WIN_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = (cnt_q == win_len - WIN_W'(1));
  assign win_end   = enabled && ms_tick && !restart && last_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (restart || !enabled) cnt_q <= '0;
    else if (ms_tick)             cnt_q <= win_end ? '0 : cnt_q + WIN_W'(1);
  end

  // R1: the tick count never reaches the window length
  a_r1_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |-> cnt_q < win_len);
  // R8: a write always leaves the window at its start
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
endmodule

// File: rtl/sfm_err_accum.sv
module sfm_err_accum #(
  parameter int ERR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enabled,
  input  logic                     restart,
  input  logic                     win_end,
  input  logic                     err_vld,
  input  logic [ERR_W-1:0]         err_cnt,
  output logic [sfm_pkg::TOT_W-1:0] total
);
  import sfm_pkg::*;

  logic [TOT_W-1:0] acc_q;
  logic [TOT_W-1:0] inc;
  logic             take;

  assign take  = err_vld && !restart && enabled;
  assign inc   = take ? TOT_W'(err_cnt) : '0;
  assign total = sat_add(acc_q, inc);

  always_ff @(posedge clk) begin
    if (!rst_n)                              acc_q <= '0;
    else if (restart || !enabled || win_end) acc_q <= '0;
    else if (take)                           acc_q <= total;
  end

  // R3: inside a window the running sum never decreases (no wrap)
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && enabled && !win_end) |=> acc_q >= $past(acc_q));
  // R6: the sum starts from zero after a window closes
  a_r6_sum_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> acc_q == '0);
endmodule

// File: rtl/sf_defect_monitor.sv
module sf_defect_monitor #(
  parameter int ERR_W = 8,
  parameter int WIN_W = 24,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             err_vld,
  input  logic [ERR_W-1:0] err_cnt,
  input  logic             cfg_wr,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic             sf_active,
  output logic             sf_change
);
  import sfm_pkg::*;

  logic [WIN_W-1:0] win_len;
  logic [TOT_W-1:0] set_lim;
  logic [TOT_W-1:0] clr_lim;
  logic [TOT_W-1:0] total;
  logic             restart;
  logic             enabled;
  logic             win_end;
  logic             flag_next;
  logic             sf_q;
  logic             chg_q;

  sfm_cfg_regs #(.WIN_W(WIN_W), .THR_W(TOT_W), .SEL_W(SEL_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .win_len(win_len), .set_lim(set_lim),
    .clr_lim(clr_lim), .restart(restart));

  assign enabled = (win_len != '0);

  sfm_window_timer #(.WIN_W(WIN_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .enabled(enabled), .restart(restart),
    .ms_tick(ms_tick), .win_len(win_len), .win_end(win_end));

  sfm_err_accum #(.ERR_W(ERR_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .enabled(enabled), .restart(restart),
    .win_end(win_end), .err_vld(err_vld), .err_cnt(err_cnt), .total(total));

  assign flag_next = next_flag(sf_q, total, set_lim, clr_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf_q  <= 1'b0;
      chg_q <= 1'b0;
    end else if (!enabled) begin
      sf_q  <= 1'b0;
      chg_q <= sf_q;
    end else if (win_end) begin
      sf_q  <= flag_next;
      chg_q <= flag_next != sf_q;
    end else begin
      chg_q <= 1'b0;
    end
  end

  assign sf_active = sf_q;
  assign sf_change = chg_q;

  // R9: pulse marks exactly the cycles where the flag differs from before
  a_r9_change_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sf_change == (sf_active != $past(sf_active)));
  // R6: the flag rises only after a window close
  a_r6_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sf_active) |-> $past(win_end));
  // R7: a zero window holds the flag low
  a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !sf_active);
  // R4: a raise needs a total above the set limit
  a_r4_strict_set: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !sf_q && total <= set_lim) |=> !sf_active);
endmodule

// File: tb/sf_defect_monitor_tb_top.sv
`timescale 1ns/1ps
module sf_defect_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       err_vld = 1'b0;
  logic [7:0] err_cnt = 8'd0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       sf_active;
  logic       sf_change;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sf_defect_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .err_vld(err_vld),
    .err_cnt(err_cnt), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sf_active(sf_active), .sf_change(sf_change));

  // Window of 4 ticks, set limit 10, clear limit 3: totals and expected flag
  localparam int NV = 8;
  localparam int VEC_ERR [NV] = '{11, 5, 3, 10, 0, 200, 4, 0};
  localparam bit VEC_EXP [NV] = '{1,  1, 0, 0,  0, 1,   1, 0};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int sel, input int val);
    cfg_wr = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 8'(val);
    cyc();
    cfg_wr = 1'b0;
  endtask

  task automatic err(input int n);
    err_vld = 1'b1; err_cnt = 8'(n);
    cyc();
    err_vld = 1'b0;
  endtask

  task automatic tick(input int n);
    ms_tick = 1'b1; err_vld = (n != 0); err_cnt = 8'(n);
    cyc();
    ms_tick = 1'b0; err_vld = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit prev;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R7 reset flag", sf_active, 0);
    chk("R9 reset pulse", sf_change, 0);

    // R2 default set limit 0xFFFF: saturated total must not raise
    wr(0, 2);
    for (int i = 0; i < 260; i++) err(255);
    tick(0); tick(0);
    chk("R2 default limit", sf_active, 0);

    // R3 saturation against set limit 0xFFFE
    wr(3, 8'hFE);
    for (int i = 0; i < 258; i++) err(255);
    tick(0); tick(0);
    chk("R3 saturate raises", sf_active, 1);
    chk("R9 rise pulse", sf_change, 1);
    cyc();
    chk("R9 pulse one cycle", sf_change, 0);
    tick(0); tick(0);
    chk("R2 default clear limit", sf_active, 0);

    // table walk with set 10, clear 3, window 4
    wr(3, 10); wr(4, 0); wr(5, 3); wr(6, 0); wr(0, 4);
    prev = 1'b0;
    for (int v = 0; v < NV; v++) begin
      err(VEC_ERR[v] / 2);
      tick(0); tick(0);
      chk("R6 no mid-window change", sf_active, int'(prev));
      tick(0);
      tick(VEC_ERR[v] - VEC_ERR[v] / 2);
      chk("R4 R5 table flag", sf_active, int'(VEC_EXP[v]));
      chk("R9 table pulse", sf_change, int'(VEC_EXP[v] != prev));
      prev = VEC_EXP[v];
    end

    // R8 mid-window write discards earlier errors
    err(8); tick(0); tick(0);
    wr(4, 0);
    err(5); tick(0); tick(0);
    chk("R8 old window end ignored", sf_active, 0);
    tick(0); tick(0);
    chk("R8 restarted total", sf_active, 0);

    // R1 upper window byte: 256-tick window
    wr(0, 0); wr(1, 1);
    err(20);
    for (int i = 0; i < 255; i++) tick(0);
    chk("R1 before 256th tick", sf_active, 0);
    tick(0);
    chk("R1 at 256th tick", sf_active, 1);

    // R7 zero window forces clear and pulses
    wr(1, 0);
    cyc();
    chk("R7 forced clear", sf_active, 0);
    chk("R9 forced clear pulse", sf_change, 1);
    for (int i = 0; i < 6; i++) begin
      err(200); tick(100);
    end
    chk("R7 stays clear", sf_active, 0);
    chk("R7 no pulse", sf_change, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule